// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block brings a smart card's contacts up and down in a safe, fixed order. It counts time in ticks. One tick is a fixed number of clocks of a slow free-running oscillator, and it sets the order and spacing of every contact change. A host asks for a session by pulling its active-low start request low. The block then turns on the charge-pump enable and releases the low-impedance clamp on the contacts. It raises the card supply, enables the data line and finally enables the reset buffer. When the session ends, the block takes the same contacts down in the reverse order.

While the data line is enabled and the reset buffer is not yet enabled, the host's reset/clock control pin drives the card clock gate directly. This lets the host count clock pulses exactly during the card's answer to reset. After that window the clock runs continuously, and the same host pin drives the card reset contact, inverted. A contact fault, a supply alarm or a card removal during a session starts the same takedown at once. It also pulls the host flag `off_n` low. After a removal, that flag stays low until a card is present again.

Top module: `card_power_seq`

## Requirements
- R1: After reset, `lowz_hold` is 1 and `off_n` is 1. `boost_en`, `vcc_en`, `io_en`, `card_clk_en`, `rst_buf_en` and `card_rst` are 0.
- R2: A session starts only on a high-to-low transition of `start_n` while idle, with `card_present`=1, `supply_alarm`=0 and `contact_fault`=0. In any other case all contacts stay in the R1 state.
- R3: One tick lasts TICK_DIV clocks (64 by default). Let t1 be the first tick after acceptance, when `boost_en` rises. At t1+1 tick, `lowz_hold` falls and `vcc_en` rises. At t1+4 ticks, `io_en` rises. At t1+7 ticks, `rst_buf_en` rises. In every cycle, `vcc_en` implies `boost_en`, `io_en` implies `vcc_en`, `rst_buf_en` implies `io_en`, and `lowz_hold` implies not `vcc_en`.
- R4: During activation, `card_clk_en` is 0 before `io_en` rises, whatever `host_rstin` does. From `io_en` rising until `rst_buf_en` rises, `card_clk_en` equals `host_rstin`.
- R5: Once `rst_buf_en` is 1, `card_clk_en` is 1 whatever `host_rstin` does, and `card_rst` equals the inverse of `host_rstin`. While `rst_buf_en` is 0, `card_rst` is 0.
- R6: Raising `start_n` during a session begins a takedown. Let t10 be the first tick after the request; `rst_buf_en` falls there. `card_clk_en` falls half a tick later. `io_en` falls at t10+1 tick and `vcc_en` at t10+2 ticks. At t10+5 ticks, `boost_en` falls and `lowz_hold` rises. `off_n` stays 1 throughout.
- R7: Any of the following during activation or an active session starts the R6 takedown and drives `off_n` to 0 from the next clock: `contact_fault`=1, `supply_alarm`=1 or `card_present`=0.
- R8: After a fault- or alarm-caused takedown, `off_n` returns to 1 when the idle state is reached. After a removal-caused takedown, `off_n` stays 0 until `card_present` is 1 while idle.
- R9: A falling edge of `start_n` during a takedown is ignored. The block reaches idle and stays there until a new falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Session request, active low |
| card_present | input | 1 | Card detected in the slot |
| supply_alarm | input | 1 | Supply voltage too low |
| contact_fault | input | 1 | Overcurrent or contact short detected |
| host_rstin | input | 1 | Host clock gate in the answer window, inverted card reset afterwards |
| boost_en | output | 1 | Charge-pump converter enable |
| lowz_hold | output | 1 | Clamp contacts low-impedance to ground |
| vcc_en | output | 1 | Card supply ramp enable |
| io_en | output | 1 | Data line buffer enable |
| card_clk_en | output | 1 | Card clock gate |
| rst_buf_en | output | 1 | Card reset buffer enable |
| card_rst | output | 1 | Card reset contact level |
| off_n | output | 1 | Host flag, low on fault or card removal |

## Verification
The embedded properties check every cycle that no contact is on without the contact below it in the stack. They also check that a fault in a session drops `off_n` on the next clock, that an absent card holds the block idle, and that a takedown never turns back into an activation. Only the bench's scenarios show the exact tick positions of each step, the half-tick clock stop and the clock window controlled by `host_rstin`. The same holds for the latched `off_n` after removal and the ignored start edge during takedown. Randomly timed aborts at arbitrary points of activation show that a partial power-up is still taken down in order.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_UP,
        PH_ON,
        PH_DOWN
    } phase_e;

    typedef struct packed {
        logic boost;
        logic lowz;
        logic vcc;
        logic io;
        logic clk;
        logic rst;
    } contacts_t;

    localparam contacts_t CONTACTS_SAFE = '{
        boost: 1'b0, lowz: 1'b1, vcc: 1'b0, io: 1'b0, clk: 1'b0, rst: 1'b0
    };

    function automatic logic may_open(input logic present, input logic alarm,
                                      input logic fault);
        return present & ~alarm & ~fault;
    endfunction

    function automatic logic must_abort(input logic present, input logic alarm,
                                        input logic fault);
        return ~present | alarm | fault;
    endfunction

endpackage

// File: rtl/cardseq_tick.sv
module cardseq_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic half
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == CW'(DIV - 1));
    assign half = (cnt_q == CW'(DIV / 2 - 1));

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/cardseq_fsm.sv
module cardseq_fsm
    import cardseq_pkg::*;
#(
    parameter int RAMP_TICKS = 3,
    parameter int ATR_TICKS  = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      half,
    input  logic      start_n,
    input  logic      card_present,
    input  logic      supply_alarm,
    input  logic      contact_fault,
    output contacts_t con,
    output logic      atr_window,
    output logic      off_n
);
    localparam int STEP_BOOST = 1;
    localparam int STEP_VCC   = 2;
    localparam int STEP_IO    = STEP_VCC + RAMP_TICKS;
    localparam int STEP_RST   = STEP_IO + ATR_TICKS;
    localparam int DOWN_RST   = 1;
    localparam int DOWN_IO    = 2;
    localparam int DOWN_VCC   = 3;
    localparam int DOWN_END   = DOWN_VCC + RAMP_TICKS;
    localparam int STEP_W     = $clog2(STEP_RST + 2);

    phase_e            phase;
    logic [STEP_W-1:0] step, nxt;
    contacts_t         con_q;
    logic              emerg_q, removed_q, start_prev_q;
    logic              cause, open_req;

    always_comb begin
        nxt      = step + 1'b1;
        cause    = must_abort(card_present, supply_alarm, contact_fault);
        open_req = start_prev_q & ~start_n &
                   may_open(card_present, supply_alarm, contact_fault);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            step         <= '0;
            con_q        <= CONTACTS_SAFE;
            emerg_q      <= 1'b0;
            removed_q    <= 1'b0;
            start_prev_q <= 1'b1;
        end else begin
            start_prev_q <= start_n;
            unique case (phase)
                PH_IDLE: begin
                    if (card_present) removed_q <= 1'b0;
                    if (open_req) begin
                        phase <= PH_UP;
                        step  <= '0;
                    end
                end
                PH_UP, PH_ON: begin
                    if (cause || start_n) begin
                        phase <= PH_DOWN;
                        step  <= '0;
                        if (cause) emerg_q <= 1'b1;
                        if (!card_present) removed_q <= 1'b1;
                    end else if (phase == PH_UP && tick) begin
                        step <= nxt;
                        if (nxt == STEP_W'(STEP_BOOST)) con_q.boost <= 1'b1;
                        if (nxt == STEP_W'(STEP_VCC)) begin
                            con_q.lowz <= 1'b0;
                            con_q.vcc  <= 1'b1;
                        end
                        if (nxt == STEP_W'(STEP_IO)) con_q.io <= 1'b1;
                        if (nxt == STEP_W'(STEP_RST)) begin
                            con_q.rst <= 1'b1;
                            con_q.clk <= 1'b1;
                            phase     <= PH_ON;
                        end
                    end
                end
                PH_DOWN: begin
                    if (cause) emerg_q <= 1'b1;
                    if (!card_present) removed_q <= 1'b1;
                    if (half && step == STEP_W'(DOWN_RST)) con_q.clk <= 1'b0;
                    if (tick) begin
                        step <= nxt;
                        if (nxt == STEP_W'(DOWN_RST)) con_q.rst <= 1'b0;
                        if (nxt == STEP_W'(DOWN_IO))  con_q.io  <= 1'b0;
                        if (nxt == STEP_W'(DOWN_VCC)) con_q.vcc <= 1'b0;
                        if (nxt == STEP_W'(DOWN_END)) begin
                            con_q   <= CONTACTS_SAFE;
                            phase   <= PH_IDLE;
                            step    <= '0;
                            emerg_q <= 1'b0;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign con        = con_q;
    assign atr_window = (phase == PH_UP) && con_q.io;
    assign off_n      = ~(emerg_q | removed_q);

    AST_VCC_NEEDS_BOOST: assert property (@(posedge clk) disable iff (rst)
        con_q.vcc |-> con_q.boost); // R3
    AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
        con_q.io |-> con_q.vcc); // R3
    AST_RST_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
        con_q.rst |-> con_q.io); // R3
    AST_CLAMP_NO_VCC: assert property (@(posedge clk) disable iff (rst)
        con_q.lowz |-> !con_q.vcc); // R3
    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
        con_q.clk |-> con_q.io); // R5
    AST_NO_CARD_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !card_present) |=> phase == PH_IDLE); // R2
    AST_FAULT_DROPS_OFF: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_UP || phase == PH_ON) && contact_fault) |=> !off_n); // R7
    AST_DOWN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        phase == PH_DOWN |=> (phase == PH_DOWN || phase == PH_IDLE)); // R9

endmodule

// File: rtl/cardseq_pins.sv
module cardseq_pins
    import cardseq_pkg::*;
(
    input  contacts_t con,
    input  logic      atr_window,
    input  logic      host_rstin,
    output logic      boost_en,
    output logic      lowz_hold,
    output logic      vcc_en,
    output logic      io_en,
    output logic      card_clk_en,
    output logic      rst_buf_en,
    output logic      card_rst
);
    assign boost_en    = con.boost;
    assign lowz_hold   = con.lowz;
    assign vcc_en      = con.vcc;
    assign io_en       = con.io;
    assign rst_buf_en  = con.rst;
    assign card_clk_en = atr_window ? host_rstin : con.clk;
    assign card_rst    = con.rst & ~host_rstin;
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
    import cardseq_pkg::*;
#(
    parameter int TICK_DIV   = 64,
    parameter int RAMP_TICKS = 3,
    parameter int ATR_TICKS  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    input  logic card_present,
    input  logic supply_alarm,
    input  logic contact_fault,
    input  logic host_rstin,
    output logic boost_en,
    output logic lowz_hold,
    output logic vcc_en,
    output logic io_en,
    output logic card_clk_en,
    output logic rst_buf_en,
    output logic card_rst,
    output logic off_n
);
    logic      tick, half, atr_window;
    contacts_t con;

    cardseq_tick #(.DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .half (half)
    );

    cardseq_fsm #(.RAMP_TICKS(RAMP_TICKS), .ATR_TICKS(ATR_TICKS)) fsm_i (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .half          (half),
        .start_n       (start_n),
        .card_present  (card_present),
        .supply_alarm  (supply_alarm),
        .contact_fault (contact_fault),
        .con           (con),
        .atr_window    (atr_window),
        .off_n         (off_n)
    );

    cardseq_pins pins_i (
        .con         (con),
        .atr_window  (atr_window),
        .host_rstin  (host_rstin),
        .boost_en    (boost_en),
        .lowz_hold   (lowz_hold),
        .vcc_en      (vcc_en),
        .io_en       (io_en),
        .card_clk_en (card_clk_en),
        .rst_buf_en  (rst_buf_en),
        .card_rst    (card_rst)
    );
endmodule

// File: tb/card_power_seq_tb_top.sv
module card_power_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 64;
    localparam logic [5:0] SAFE = 6'b010000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1, card_present = 1'b1, supply_alarm = 1'b0;
    logic contact_fault = 1'b0, host_rstin = 1'b0;
    logic boost_en, lowz_hold, vcc_en, io_en, card_clk_en, rst_buf_en, card_rst, off_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    card_power_seq dut_i (
        .clk(clk), .rst(rst), .start_n(start_n), .card_present(card_present),
        .supply_alarm(supply_alarm), .contact_fault(contact_fault),
        .host_rstin(host_rstin), .boost_en(boost_en), .lowz_hold(lowz_hold),
        .vcc_en(vcc_en), .io_en(io_en), .card_clk_en(card_clk_en),
        .rst_buf_en(rst_buf_en), .card_rst(card_rst), .off_n(off_n)
    );

    function automatic logic [5:0] pins();
        return {boost_en, lowz_hold, vcc_en, io_en, card_clk_en, rst_buf_en};
    endfunction

    // expected contacts n ticks after t1 (host_rstin held 0)
    function automatic logic [5:0] exp_up(input int n);
        return {1'b1, n < 1, n >= 1, n >= 4, n >= 7, n >= 7};
    endfunction

    function automatic logic order_ok(input logic [5:0] v);
        return !(v[3] && !v[5]) && !(v[2] && !v[3]) && !(v[0] && !v[2]) &&
               !(v[4] && v[3]);
    endfunction

    function automatic logic exp_off_after(input int kind);
        return (kind == 3) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic activate_checked();
        int guard = 0;
        start_n = 1'b0;
        while (!boost_en && guard < 2 * T) begin
            @(negedge clk);
            guard++;
        end
        chk("R3 boost within one tick", 8'(guard <= T + 1), 8'd1);
        wait_cyc(32);
        for (int n = 0; n < 8; n++) begin
            chk("R3 activation step", 8'(pins()), 8'(exp_up(n)));
            if (n == 2) begin
                host_rstin = 1'b1;
                wait_cyc(1);
                chk("R4 clock held before io", 8'(card_clk_en), 8'd0);
                host_rstin = 1'b0;
            end else if (n >= 4 && n <= 6) begin
                host_rstin = 1'b1;
                wait_cyc(1);
                chk("R4 clock follows host in window", 8'(card_clk_en), 8'd1);
                host_rstin = 1'b0;
            end else begin
                wait_cyc(1);
            end
            wait_cyc(T - 1);
        end
    endtask

    task automatic deactivate_checked(input logic off_exp);
        int guard = 0;
        while (rst_buf_en && guard < 2 * T) begin
            @(negedge clk);
            guard++;
        end
        chk("R6 reset buffer off within one tick", 8'(guard <= T + 1), 8'd1);
        wait_cyc(16);
        chk("R6 clock before half tick", 8'(pins()), 8'b10_1110);
        chk("R6 R7 off_n during takedown", 8'(off_n), 8'(off_exp));
        chk("R5 card_rst low with buffer off", 8'(card_rst), 8'd0);
        wait_cyc(32);
        chk("R6 clock stopped at half tick", 8'(pins()), 8'b10_1100);
        wait_cyc(T);
        chk("R6 io off at t10+T", 8'(pins()), 8'b10_1000);
        wait_cyc(T);
        chk("R6 vcc off at t10+2T", 8'(pins()), 8'b10_0000);
        wait_cyc(2 * T);
        chk("R6 boost held until t10+5T", 8'(pins()), 8'b10_0000);
        wait_cyc(T);
        chk("R6 clamp restored at t10+5T", 8'(pins()), 8'(SAFE));
    endtask

    task automatic quick_up();
        start_n = 1'b0;
        wait_cyc(9 * T);
        chk("R3 session active", 8'(rst_buf_en), 8'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 reset contacts", 8'(pins()), 8'(SAFE));
        chk("R1 reset flag and card_rst", 8'({off_n, card_rst}), 8'b10);

        // R2 rejection cases
        card_present = 1'b0; start_n = 1'b0;
        wait_cyc(3 * T);
        chk("R2 no card rejected", 8'(pins()), 8'(SAFE));
        start_n = 1'b1; card_present = 1'b1; supply_alarm = 1'b1;
        wait_cyc(2);
        start_n = 1'b0;
        wait_cyc(3 * T);
        chk("R2 alarm rejected", 8'(pins()), 8'(SAFE));
        supply_alarm = 1'b0;
        wait_cyc(3 * T);
        chk("R2 held low without edge stays idle", 8'(pins()), 8'(SAFE));
        start_n = 1'b1;
        wait_cyc(2);

        // R3 R4 R5 full activation and R6 normal takedown
        activate_checked();
        host_rstin = 1'b1;
        wait_cyc(2);
        chk("R5 clock steady, rst low", 8'({card_clk_en, card_rst}), 8'b10);
        host_rstin = 1'b0;
        wait_cyc(2);
        chk("R5 clock steady, rst high", 8'({card_clk_en, card_rst}), 8'b11);
        start_n = 1'b1;
        deactivate_checked(1'b1);
        chk("R6 off_n after normal end", 8'(off_n), 8'd1);

        // R9 start edge during takedown ignored
        wait_cyc(4);
        quick_up();
        start_n = 1'b1;
        wait_cyc(2 * T);
        start_n = 1'b0;
        wait_cyc(6 * T);
        chk("R9 idle after takedown", 8'(pins()), 8'(SAFE));
        wait_cyc(3 * T);
        chk("R9 start edge ignored", 8'(pins()), 8'(SAFE));
        start_n = 1'b1;
        wait_cyc(2);

        // R7 R8 removal
        quick_up();
        card_present = 1'b0;
        wait_cyc(2);
        chk("R7 off_n low on removal", 8'(off_n), 8'd0);
        deactivate_checked(1'b0);
        wait_cyc(T);
        chk("R8 off_n held after removal", 8'(off_n), 8'd0);
        card_present = 1'b1;
        wait_cyc(2);
        chk("R8 off_n released on insertion", 8'(off_n), 8'd1);
        start_n = 1'b1;
        wait_cyc(2);

        // R7 R8 contact fault
        quick_up();
        contact_fault = 1'b1;
        wait_cyc(1);
        contact_fault = 1'b0;
        wait_cyc(1);
        chk("R7 off_n low on fault", 8'(off_n), 8'd0);
        deactivate_checked(1'b0);
        chk("R8 off_n back after fault", 8'(off_n), 8'd1);
        start_n = 1'b1;
        wait_cyc(2);

        // R7 R8 supply alarm
        quick_up();
        supply_alarm = 1'b1;
        wait_cyc(2);
        chk("R7 off_n low on alarm", 8'(off_n), 8'd0);
        supply_alarm = 1'b0;
        deactivate_checked(1'b0);
        chk("R8 off_n back after alarm", 8'(off_n), 8'd1);
        start_n = 1'b1;
        wait_cyc(2);

        // random abort points during activation and session
        for (int it = 0; it < 20; it++) begin
            int w;
            int kind;
            bit bad;
            w = $urandom_range(0, 10 * T);
            kind = $urandom_range(0, 3);
            bad = 1'b0;
            start_n = 1'b0;
            wait_cyc(w);
            case (kind)
                0: start_n = 1'b1;
                1: contact_fault = 1'b1;
                2: supply_alarm = 1'b1;
                default: card_present = 1'b0;
            endcase
            wait_cyc(1);
            contact_fault = 1'b0;
            supply_alarm = 1'b0;
            for (int c = 0; c < 7 * T; c++) begin
                @(negedge clk);
                if (!order_ok(pins())) bad = 1'b1;
            end
            chk("R3 contact order under random abort", 8'(bad), 8'd0);
            chk("R6 R7 safe after random abort", 8'(pins()), 8'(SAFE));
            chk("R8 off_n after random abort", 8'(off_n), 8'(exp_off_after(kind)));
            start_n = 1'b1;
            card_present = 1'b1;
            wait_cyc(4);
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule